// File: doc/BRIEF.md
# Dual-Byte Boundary-Scan Bus Transceiver

The block holds two independent 9-bit bidirectional transceiver lanes. Each lane has an active-high disable input and a transfer-direction input. When enabled, a lane copies one side to the other with no inversion. Pads are modelled as separate input, output and output-enable vectors, with one enable bit per pin.

An 80-cell boundary-scan register sits between the pads and the transceiver core. Observe-only cells cover every input, including the direction and disable controls. Controlling cells, each backed by a parallel hold latch, cover every output and the internal per-lane enables for the A and B drivers.

An external test-access controller supplies the capture, shift and update strobes and a register-select qualifier. It also supplies decoded flags for external test, clamp and all-outputs-off. While external test or clamp is active, the pads are driven from the hold latches. While the all-off flag is high, every output enable is forced low.

Top module: `dbs_xcvr`

## Requirements
- R1: Outside the test modes, a lane whose `byte_dis` bit is 1 drives neither side: all nine of its `a_oe` bits and all nine of its `b_oe` bits are 0, whatever its `xfer_ab` bit is.
- R2: Outside the test modes, a lane with `byte_dis`=0 and `xfer_ab`=0 drives the A side. Its `a_oe` bits are all 1 and its `b_oe` bits are all 0. `a_out` always equals `b_in` in this mode.
- R3: Outside the test modes, a lane with `byte_dis`=0 and `xfer_ab`=1 drives the B side. Its `b_oe` bits are all 1 and its `a_oe` bits are all 0. `b_out` always equals `a_in`. A lane never enables both sides at once.
- R4: The two lanes are independent. Lane k uses pins k*9 to k*9+8 of every vector and bit k of `byte_dis` and `xfer_ab`.
- R5: A capture strobe loads every cell with its system node, as follows.
  - Control region, for lane k: cell 79-4k takes `xfer_ab`, cell 78-4k takes `byte_dis`, cell 77-4k takes the core A-drive enable and cell 76-4k takes the core B-drive enable.
  - Pin groups, in descending order: A inputs (71..54), core B-output data (53..36), B inputs (35..18), core A-output data (17..0).
  - Within each pin group, lane 0 takes the upper nine cells. Pin 0 of a lane sits at the highest index of its nine.
- R6: Each shift strobe moves the chain one cell toward index 0. `scan_in` enters cell 79, and `scan_out` shows cell 0.
- R7: An update strobe copies the shift stage of every controlling cell into its hold latch. Hold latches change on no other event.
- R8: While external test or clamp is active and all-off is not, the outputs come from the hold latches:
  - `a_out` and `b_out` come from the latches of the A-output and B-output cells;
  - every `a_oe` bit of a lane equals its A-enable latch, and every `b_oe` bit equals its B-enable latch.
- R9: While `tm_highz` is 1, every `a_oe` and `b_oe` bit is 0. This overrides the other modes.
- R10: Reset clears every shift stage and every hold latch. With external test active, all outputs and enables are then 0 and `scan_out` is 0.
- R11: While `bsr_select` is 0, the capture, shift and update strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_dis | input | 2 | Per-lane disable, 1 turns both sides off |
| xfer_ab | input | 2 | Per-lane direction, 1 = A to B, 0 = B to A |
| a_in | input | 18 | A-side pad inputs |
| a_out | output | 18 | A-side pad output data |
| a_oe | output | 18 | A-side per-pin output enable |
| b_in | input | 18 | B-side pad inputs |
| b_out | output | 18 | B-side pad output data |
| b_oe | output | 18 | B-side per-pin output enable |
| bsr_select | input | 1 | Boundary register selected by the controller |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| scan_in | input | 1 | Serial data into cell 79 |
| scan_out | output | 1 | Serial data from cell 0 |
| tm_extest | input | 1 | External-test flag |
| tm_clamp | input | 1 | Clamp flag |
| tm_highz | input | 1 | All-outputs-off flag |

## Verification
Several properties are checked on every cycle:
- a disabled lane stays off, and no lane drives both sides;
- the all-off flag silences every enable;
- `scan_out` advances exactly one cell per shift and holds still while the register is deselected;
- hold latches move only on update.

Only the bench scenarios can show the exact 80-cell capture layout and the path of serial data through the whole chain. The same holds for the values that external test and clamp put on the pads after an update, and for the data routing of every disable and direction combination.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  // pin group order inside the chain, highest group first
  localparam int GRP_A_IN  = 0;
  localparam int GRP_B_OUT = 1;
  localparam int GRP_B_IN  = 2;
  localparam int GRP_A_OUT = 3;

  // control cells per lane, highest first
  localparam int SIG_DIR = 0;
  localparam int SIG_DIS = 1;
  localparam int SIG_AEN = 2;
  localparam int SIG_BEN = 3;

  function automatic int chain_len(input int w, input int nb);
    return 4 * nb * (w + 1);
  endfunction

  function automatic int ctl_idx(input int w, input int nb, input int sig, input int k);
    return chain_len(w, nb) - 1 - 4 * k - sig;
  endfunction

  function automatic int pin_idx(input int w, input int nb, input int grp, input int k,
                                 input int i);
    return 4 * nb * w - 1 - grp * nb * w - k * w - i;
  endfunction

endpackage

// File: rtl/dbs_core.sv
module dbs_core #(
  parameter int W  = 9,
  parameter int NB = 2
) (
  input  logic [NB-1:0]   byte_dis,
  input  logic [NB-1:0]   xfer_ab,
  input  logic [NB*W-1:0] a_in,
  input  logic [NB*W-1:0] b_in,
  output logic [NB*W-1:0] core_a_out,
  output logic [NB*W-1:0] core_b_out,
  output logic [NB-1:0]   core_aen,
  output logic [NB-1:0]   core_ben
);

  assign core_a_out = b_in;
  assign core_b_out = a_in;
  assign core_aen   = ~byte_dis & ~xfer_ab;
  assign core_ben   = ~byte_dis &  xfer_ab;

endmodule

// File: rtl/dbs_chain.sv
module dbs_chain
  import dbs_pkg::*;
#(
  parameter int W  = 9,
  parameter int NB = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_en,
  input  logic                        shift_en,
  input  logic                        upd_en,
  input  logic                        scan_in,
  input  logic [chain_len(W,NB)-1:0]  cap_val,
  output logic                        scan_out,
  output logic [NB*W-1:0]             hold_a_out,
  output logic [NB*W-1:0]             hold_b_out,
  output logic [NB-1:0]               hold_aen,
  output logic [NB-1:0]               hold_ben
);

  localparam int L = chain_len(W, NB);

  logic [L-1:0] stage;

  // shift stages, one per cell
  for (genvar j = 0; j < L; j++) begin : g_cell
    logic q;
    logic nxt;
    if (j == L - 1) begin : g_head
      assign nxt = scan_in;
    end else begin : g_link
      assign nxt = stage[j+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (cap_en)   q <= cap_val[j];
      else if (shift_en) q <= nxt;
    end
    assign stage[j] = q;
  end

  assign scan_out = stage[0];

  // hold latches behind the output-pin cells
  for (genvar k = 0; k < NB; k++) begin : g_lane
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic ha, hb;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ha <= 1'b0;
          hb <= 1'b0;
        end else if (upd_en) begin
          ha <= stage[pin_idx(W, NB, GRP_A_OUT, k, i)];
          hb <= stage[pin_idx(W, NB, GRP_B_OUT, k, i)];
        end
      end
      assign hold_a_out[k*W+i] = ha;
      assign hold_b_out[k*W+i] = hb;
    end

    // hold latches behind the internal enable cells
    logic hae, hbe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hae <= 1'b0;
        hbe <= 1'b0;
      end else if (upd_en) begin
        hae <= stage[ctl_idx(W, NB, SIG_AEN, k)];
        hbe <= stage[ctl_idx(W, NB, SIG_BEN, k)];
      end
    end
    assign hold_aen[k] = hae;
    assign hold_ben[k] = hbe;
  end

  // R6: one cell per shift strobe toward the output end
  a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (scan_out == $past(stage[1])));

  // R7: latches only move on update
  a_r7_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable({hold_a_out, hold_b_out, hold_aen, hold_ben}));

endmodule

// File: rtl/dbs_pin_mux.sv
module dbs_pin_mux #(
  parameter int W  = 9,
  parameter int NB = 2
) (
  input  logic [NB*W-1:0] core_a_out,
  input  logic [NB*W-1:0] core_b_out,
  input  logic [NB-1:0]   core_aen,
  input  logic [NB-1:0]   core_ben,
  input  logic [NB*W-1:0] hold_a_out,
  input  logic [NB*W-1:0] hold_b_out,
  input  logic [NB-1:0]   hold_aen,
  input  logic [NB-1:0]   hold_ben,
  input  logic            tm_extest,
  input  logic            tm_clamp,
  input  logic            tm_highz,
  output logic [NB*W-1:0] a_out,
  output logic [NB*W-1:0] a_oe,
  output logic [NB*W-1:0] b_out,
  output logic [NB*W-1:0] b_oe
);

  logic          test_drive;
  logic [NB-1:0] aen, ben;

  always_comb begin
    test_drive = tm_extest | tm_clamp;
    a_out = test_drive ? hold_a_out : core_a_out;
    b_out = test_drive ? hold_b_out : core_b_out;
    if (tm_highz) begin
      aen = '0;
      ben = '0;
    end else if (test_drive) begin
      aen = hold_aen;
      ben = hold_ben;
    end else begin
      aen = core_aen;
      ben = core_ben;
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign a_oe[k*W +: W] = {W{aen[k]}};
    assign b_oe[k*W +: W] = {W{ben[k]}};
  end

endmodule

// File: rtl/dbs_xcvr.sv
module dbs_xcvr
  import dbs_pkg::*;
#(
  parameter int W  = 9,
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB-1:0]   byte_dis,
  input  logic [NB-1:0]   xfer_ab,
  input  logic [NB*W-1:0] a_in,
  output logic [NB*W-1:0] a_out,
  output logic [NB*W-1:0] a_oe,
  input  logic [NB*W-1:0] b_in,
  output logic [NB*W-1:0] b_out,
  output logic [NB*W-1:0] b_oe,
  input  logic            bsr_select,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            scan_in,
  output logic            scan_out,
  input  logic            tm_extest,
  input  logic            tm_clamp,
  input  logic            tm_highz
);

  localparam int L = chain_len(W, NB);

  logic [NB*W-1:0] core_a_out, core_b_out, hold_a_out, hold_b_out;
  logic [NB-1:0]   core_aen, core_ben, hold_aen, hold_ben;
  logic [L-1:0]    cap_val;
  logic            cap_en, shift_en, upd_en;

  // strobes only act on the selected register (R11)
  assign cap_en   = bsr_select & capture_dr;
  assign shift_en = bsr_select & shift_dr;
  assign upd_en   = bsr_select & update_dr;

  dbs_core #(.W(W), .NB(NB)) i_core (
    .byte_dis   (byte_dis),
    .xfer_ab    (xfer_ab),
    .a_in       (a_in),
    .b_in       (b_in),
    .core_a_out (core_a_out),
    .core_b_out (core_b_out),
    .core_aen   (core_aen),
    .core_ben   (core_ben)
  );

  // capture sources laid out in chain order
  for (genvar k = 0; k < NB; k++) begin : g_cap
    assign cap_val[ctl_idx(W, NB, SIG_DIR, k)] = xfer_ab[k];
    assign cap_val[ctl_idx(W, NB, SIG_DIS, k)] = byte_dis[k];
    assign cap_val[ctl_idx(W, NB, SIG_AEN, k)] = core_aen[k];
    assign cap_val[ctl_idx(W, NB, SIG_BEN, k)] = core_ben[k];
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign cap_val[pin_idx(W, NB, GRP_A_IN,  k, i)] = a_in[k*W+i];
      assign cap_val[pin_idx(W, NB, GRP_B_OUT, k, i)] = core_b_out[k*W+i];
      assign cap_val[pin_idx(W, NB, GRP_B_IN,  k, i)] = b_in[k*W+i];
      assign cap_val[pin_idx(W, NB, GRP_A_OUT, k, i)] = core_a_out[k*W+i];
    end
  end

  dbs_chain #(.W(W), .NB(NB)) i_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .shift_en   (shift_en),
    .upd_en     (upd_en),
    .scan_in    (scan_in),
    .cap_val    (cap_val),
    .scan_out   (scan_out),
    .hold_a_out (hold_a_out),
    .hold_b_out (hold_b_out),
    .hold_aen   (hold_aen),
    .hold_ben   (hold_ben)
  );

  dbs_pin_mux #(.W(W), .NB(NB)) i_mux (
    .core_a_out (core_a_out),
    .core_b_out (core_b_out),
    .core_aen   (core_aen),
    .core_ben   (core_ben),
    .hold_a_out (hold_a_out),
    .hold_b_out (hold_b_out),
    .hold_aen   (hold_aen),
    .hold_ben   (hold_ben),
    .tm_extest  (tm_extest),
    .tm_clamp   (tm_clamp),
    .tm_highz   (tm_highz),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_out      (b_out),
    .b_oe       (b_oe)
  );

  for (genvar k = 0; k < NB; k++) begin : g_chk
    // R1: a disabled lane is silent in functional mode
    a_r1_disabled_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tm_extest || tm_clamp) && byte_dis[k])
        |-> (a_oe[k*W +: W] == '0 && b_oe[k*W +: W] == '0));
    // R3: a lane never enables both sides in functional mode
    a_r3_single_side: assert property (@(posedge clk) disable iff (!rst_n)
      !(tm_extest || tm_clamp) |-> !((|a_oe[k*W +: W]) && (|b_oe[k*W +: W])));
  end

  // R9: all-off flag silences every enable
  a_r9_highz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tm_highz |-> (a_oe == '0 && b_oe == '0));

  // R11: deselected register keeps its serial output
  a_r11_deselected_still: assert property (@(posedge clk) disable iff (!rst_n)
    !bsr_select |=> $stable(scan_out));

endmodule

// File: tb/test_dbs_xcvr.sv
module test_dbs_xcvr;

  localparam int W = 9;
  localparam int NB = 2;
  localparam int L = 80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  byte_dis, xfer_ab;
  logic [17:0] a_in, b_in;
  logic [17:0] a_out, a_oe, b_out, b_oe;
  logic        bsr_select, capture_dr, shift_dr, update_dr, scan_in, scan_out;
  logic        tm_extest, tm_clamp, tm_highz;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dbs_xcvr #(.W(W), .NB(NB)) i_dbs_xcvr (
    .clk(clk), .rst_n(rst_n), .byte_dis(byte_dis), .xfer_ab(xfer_ab),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .bsr_select(bsr_select), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .scan_in(scan_in), .scan_out(scan_out),
    .tm_extest(tm_extest), .tm_clamp(tm_clamp), .tm_highz(tm_highz)
  );

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // chain image built from fields, highest cell first
  function automatic logic [79:0] pack(input logic [1:0] d, input logic [1:0] dis,
      input logic [1:0] ae, input logic [1:0] be, input logic [17:0] ai,
      input logic [17:0] bo, input logic [17:0] bi, input logic [17:0] ao);
    logic [79:0] v;
    logic [17:0] grp [4];
    int p;
    v = '0;
    p = 79;
    for (int k = 0; k < 2; k++) begin
      v[p] = d[k]; v[p-1] = dis[k]; v[p-2] = ae[k]; v[p-3] = be[k];
      p -= 4;
    end
    grp[0] = ai; grp[1] = bo; grp[2] = bi; grp[3] = ao;
    for (int g = 0; g < 4; g++)
      for (int k = 0; k < 2; k++)
        for (int i = 0; i < 9; i++) begin
          v[p] = grp[g][k*9+i];
          p--;
        end
    return v;
  endfunction

  function automatic logic [71:0] pads(input logic [1:0] ae, input logic [1:0] be,
      input logic [17:0] ao, input logic [17:0] bo);
    logic [17:0] aoe, boe;
    for (int k = 0; k < 2; k++) begin
      aoe[k*9 +: 9] = {9{ae[k]}};
      boe[k*9 +: 9] = {9{be[k]}};
    end
    return {ao, aoe, bo, boe};
  endfunction

  task automatic pulse(input logic c, input logic s, input logic u, input logic si);
    @(negedge clk);
    capture_dr = c; shift_dr = s; update_dr = u; scan_in = si;
    @(negedge clk);
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
  endtask

  task automatic scan(input logic [79:0] din, output logic [79:0] dout);
    for (int j = 0; j < L; j++) begin
      dout[j] = scan_out;
      pulse(1'b0, 1'b1, 1'b0, din[j]);
    end
  endtask

  initial begin
    #2_000_000;
    check("watchdog", 80'd1, 80'd0);
    report();
  end

  initial begin
    logic [79:0] got, img;
    logic [1:0]  ae, be;
    logic [17:0] hao, hbo;
    logic        so;
    rst_n = 1'b0; byte_dis = '0; xfer_ab = '0; a_in = 18'h15555; b_in = 18'h2AAAA;
    bsr_select = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    scan_in = 1'b0; tm_extest = 1'b1; tm_clamp = 1'b0; tm_highz = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset pads", {8'd0, a_out, a_oe, b_out, b_oe}, 80'd0);
    check("R10 reset scan_out", {79'd0, scan_out}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    tm_extest = 1'b0;

    // functional sweep: every disable/direction pair, several data patterns
    for (int m = 0; m < 16; m++)
      for (int p = 0; p < 4; p++) begin
        byte_dis = m[1:0];
        xfer_ab  = m[3:2];
        a_in = 18'(p * 18'h1357B + m * 18'h0A5C3);
        b_in = {a_in[8:0], a_in[17:9]} ^ 18'h15A5A;
        #1;
        check("R1 R2 R3 R4 functional", {8'd0, a_out, a_oe, b_out, b_oe},
              {8'd0, pads(~byte_dis & ~xfer_ab, ~byte_dis & xfer_ab, b_in, a_in)});
      end

    // capture layout
    bsr_select = 1'b1;
    for (int m = 0; m < 16; m += 3) begin
      @(negedge clk);
      byte_dis = m[1:0];
      xfer_ab  = m[3:2];
      a_in = 18'(m * 18'h0B1D3 + 18'h00F0F);
      b_in = ~a_in ^ 18'h0C3C3;
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      scan(80'd0, got);
      check("R5 R6 capture layout", got,
            pack(xfer_ab, byte_dis, ~byte_dis & ~xfer_ab, ~byte_dis & xfer_ab,
                 a_in, a_in, b_in, b_in));
    end

    // serial path: what goes in comes back out in order
    img = 80'h8F3C_5A96_0E71_D2B4_6C1B;
    scan(img, got);
    scan(80'd0, got);
    check("R6 shift order", got, img);

    // external test
    ae = 2'b01; be = 2'b10; hao = 18'h1D4E5; hbo = 18'h2B3C6;
    img = pack(2'b11, 2'b11, ae, be, 18'h3FFFF, hbo, 18'h3FFFF, hao);
    scan(img, got);
    tm_extest = 1'b1;
    #1;
    check("R7 no update yet", {8'd0, a_out, a_oe, b_out, b_oe}, 80'd0);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 R8 extest drive", {8'd0, a_out, a_oe, b_out, b_oe},
          {8'd0, pads(ae, be, hao, hbo)});

    // deselected strobes do nothing
    bsr_select = 1'b0;
    so = scan_out;
    for (int j = 0; j < 5; j++) pulse(1'b0, 1'b1, 1'b0, ~so);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    check("R11 scan_out held", {79'd0, scan_out}, {79'd0, so});
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 pads held", {8'd0, a_out, a_oe, b_out, b_oe},
          {8'd0, pads(ae, be, hao, hbo)});
    bsr_select = 1'b1;

    // all-off overrides external test
    tm_highz = 1'b1;
    #1;
    check("R9 highz over extest", {8'd0, a_out, a_oe, b_out, b_oe},
          {8'd0, pads(2'b00, 2'b00, hao, hbo)});
    tm_extest = 1'b0;
    #1;
    check("R9 highz functional", {8'd0, a_oe, b_oe}, 80'd0);
    tm_highz = 1'b0;

    // clamp uses the same latches
    tm_clamp = 1'b1;
    #1;
    check("R8 clamp drive", {8'd0, a_out, a_oe, b_out, b_oe},
          {8'd0, pads(ae, be, hao, hbo)});
    ae = 2'b10; be = 2'b01; hao = 18'h0A0F5; hbo = 18'h35F0A;
    img = pack(2'b00, 2'b00, ae, be, 18'd0, hbo, 18'd0, hao);
    scan(img, got);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 R8 clamp reload", {8'd0, a_out, a_oe, b_out, b_oe},
          {8'd0, pads(ae, be, hao, hbo)});
    tm_clamp = 1'b0;
    byte_dis = 2'b00; xfer_ab = 2'b01;
    #1;
    check("R2 R3 back to functional", {8'd0, a_out, a_oe, b_out, b_oe},
          {8'd0, pads(2'b10, 2'b01, b_in, a_in)});

    report();
  end

endmodule